// File: doc/BRIEF.md
# Block Floating-Point Resource-Block Codec

This block applies block floating-point compression to fronthaul IQ data, one resource block at a time. A resource block is a group of twelve complex samples. Each sample holds a signed 16-bit I part and a signed 16-bit Q part. The block accepts one IQ pair per beat on a valid/ready stream. It holds the whole group until the twelfth pair arrives. It then picks one shift exponent for all 24 components of the group, so that the largest of them fits the requested mantissa width. It emits that exponent as a one-byte parameter beat. After the parameter beat it emits twelve beats of rounded, saturated mantissas in the order the pairs arrived.

A 4-bit code, sampled with the first pair of each group, sets the mantissa width for that group. Code 0 selects 16 bits and any other code n selects n bits. A separate expansion path reverses the process. It takes a mantissa pair, a width code and an exponent, and returns rebuilt 16-bit samples one cycle later. Transmit logic uses the compressor and receive logic uses the expander. A loopback of the two also lets a test measure quantization error.

Top module: `bfp_prb_codec`

## Requirements
- R1: After reset, `out_valid` and `dx_out_valid` are 0 and `in_ready` is 1.
- R2: The compressor accepts exactly twelve pairs per group. `in_ready` stays 0 while any beat of that group is pending on the output. `in_ready` returns to 1 in the cycle after the final mantissa beat is taken.
- R3: Each group is output as one parameter beat (`out_is_param`=1) followed by twelve mantissa beats in arrival order. `out_last` is 1 only on the twelfth mantissa beat.
- R4: The width code is taken from the first pair of a group only. Codes on the later pairs of that group have no effect. Code 0 means 16 bits and code n (1..15) means n bits.
- R5: The exponent e is the smallest value in 0..15 for which every I and Q component of the group, arithmetically right-shifted by e, fits a signed word of the selected width. `out_param` equals e zero-extended to 8 bits, so bits 7:4 are 0. A group of all zeros gives e = 0.
- R6: Each mantissa equals (x + 2^(e-1)) >>> e when e > 0, and x when e = 0. The result is then clamped to [-2^(W-1), 2^(W-1)-1]. It is presented sign-extended in a 16-bit lane. During the parameter beat both lanes are 0.
- R7: While `out_valid` is 1 and `out_ready` is 0, every output of the beat holds its value. No beat is lost or repeated.
- R8: The expander registers its result one cycle after `dx_valid`. It takes the low W bits of each mantissa lane, sign-extends them, shifts them left by `dx_exp` and keeps the low 16 bits. Bits of a mantissa lane at or above W have no effect. `dx_out_valid` follows `dx_valid` with one cycle of delay.
- R9: With width code 0 every mantissa equals its input sample exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Compressor can take a pair |
| in_i | input | 16 | Signed I component |
| in_q | input | 16 | Signed Q component |
| in_wcode | input | 4 | Width code, used on the first pair of a group |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_is_param | output | 1 | Beat is the exponent parameter |
| out_last | output | 1 | Final mantissa beat of the group |
| out_param | output | 8 | Group parameter byte, exponent in bits 3:0 |
| out_mi | output | 16 | I mantissa, sign-extended |
| out_mq | output | 16 | Q mantissa, sign-extended |
| dx_valid | input | 1 | Expander input present |
| dx_wcode | input | 4 | Expander width code |
| dx_exp | input | 4 | Expander shift exponent |
| dx_mi | input | 16 | I mantissa lane for expansion |
| dx_mq | input | 16 | Q mantissa lane for expansion |
| dx_out_valid | output | 1 | Expanded pair present |
| dx_out_i | output | 16 | Rebuilt I sample |
| dx_out_q | output | 16 | Rebuilt Q sample |

## Verification
The hardest conditions to reach come from the rounding step. Rounding pushes a positive full-scale component past the top of the mantissa range, so the output must saturate. A group whose only large value is negative, such as -32768, must still get the same exponent as its positive twin. The stimulus sweeps full-scale, all-negative, near-threshold and pseudo-random groups across widths 1, 4, and 8 to 16. This lands the largest component on and beside every shift boundary. Random gaps on the input and random withholding of `out_ready` bring about stalls in the middle of a group and on the parameter beat.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
   typedef enum logic {PH_FILL = 1'b0, PH_EMIT = 1'b1} bfp_phase_t;
   localparam int N_LANES = 2;
   localparam int LANE_I  = 0;
   localparam int LANE_Q  = 1;
   localparam int PAR_W   = 8;
endpackage

// File: rtl/bfp_fold_mag.sv
// Folds a signed word into a magnitude whose bit length equals the number
// of bits the value needs beyond its sign (one's complement for negatives).
module bfp_fold_mag #(
   parameter int SAMPLE_W = 16
) (
   input  logic [SAMPLE_W-1:0] v,
   output logic [SAMPLE_W-2:0] m
);
   always_comb begin
      m = v[SAMPLE_W-1] ? ~v[SAMPLE_W-2:0] : v[SAMPLE_W-2:0];
   end
endmodule

// File: rtl/bfp_exp_calc.sv
// Smallest right shift that brings the folded magnitude below 2^(width-1).
module bfp_exp_calc #(
   parameter int MAG_W = 15,
   parameter int WID_W = 5,
   parameter int EXP_W = 4,
   parameter int ARCH  = 0
) (
   input  logic [MAG_W-1:0] mag,
   input  logic [WID_W-1:0] width,
   output logic [EXP_W-1:0] exp_o
);
   localparam int CMP_W = MAG_W + 2;
   localparam int MAX_E = (1 << EXP_W) - 1;

   if (ARCH != 0 && ARCH != 1) begin : g_bad_arch
      $error("bfp_exp_calc: ARCH must be 0 or 1");
   end

   if (ARCH == 0) begin : g_lead_one
      always_comb begin
         int blen;
         int wm1;
         int tmp;
         blen = 0;
         for (int b = 0; b < MAG_W; b++) begin
            if (mag[b]) blen = b + 1;
         end
         wm1 = int'(width) - 1;
         tmp = (blen > wm1) ? (blen - wm1) : 0;
         if (tmp > MAX_E) tmp = MAX_E;
         exp_o = EXP_W'(tmp);
      end
   end else begin : g_cmp_chain
      logic [CMP_W-1:0] lim;
      always_comb begin
         lim   = CMP_W'(1) << (width - WID_W'(1));
         exp_o = EXP_W'(MAX_E);
         for (int e = MAX_E; e >= 0; e--) begin
            if ((CMP_W'(mag) >> e) < lim) exp_o = EXP_W'(e);
         end
      end
   end
endmodule

// File: rtl/bfp_quant.sv
// Round-half-up arithmetic right shift followed by clamp to width bits.
module bfp_quant #(
   parameter int SAMPLE_W = 16,
   parameter int WID_W    = 5,
   parameter int EXP_W    = 4
) (
   input  logic [SAMPLE_W-1:0] v,
   input  logic [EXP_W-1:0]    sh,
   input  logic [WID_W-1:0]    width,
   output logic [SAMPLE_W-1:0] q
);
   localparam int EXT_W = SAMPLE_W + 2;
   logic signed [EXT_W-1:0] ext, bias, summ, shifted, hi, lo, sat;

   always_comb begin
      ext     = {{2{v[SAMPLE_W-1]}}, v};
      bias    = (sh == '0) ? '0 : (EXT_W'(1) <<< (sh - EXP_W'(1)));
      summ    = ext + bias;
      shifted = summ >>> sh;
      hi      = (EXT_W'(1) <<< (width - WID_W'(1))) - EXT_W'(1);
      lo      = -(EXT_W'(1) <<< (width - WID_W'(1)));
      if (shifted > hi)      sat = hi;
      else if (shifted < lo) sat = lo;
      else                   sat = shifted;
      q = sat[SAMPLE_W-1:0];
   end
endmodule

// File: rtl/bfp_expand.sv
// Sign-extends the low width bits of a mantissa and shifts it back up.
module bfp_expand #(
   parameter int SAMPLE_W = 16,
   parameter int WID_W    = 5,
   parameter int EXP_W    = 4
) (
   input  logic [SAMPLE_W-1:0] m,
   input  logic [EXP_W-1:0]    sh,
   input  logic [WID_W-1:0]    width,
   output logic [SAMPLE_W-1:0] y
);
   logic [WID_W-1:0]           pad;
   logic signed [SAMPLE_W-1:0] up, sx;

   always_comb begin
      pad = WID_W'(SAMPLE_W) - width;
      up  = m << pad;
      sx  = up >>> pad;
      y   = sx << sh;
   end
endmodule

// File: rtl/bfp_prb_codec.sv
module bfp_prb_codec
   import bfp_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int GROUP_N  = 12,
   parameter int CODE_W   = 4,
   parameter int EXP_W    = 4,
   parameter int EXP_ARCH = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_i,
   input  logic [SAMPLE_W-1:0] in_q,
   input  logic [CODE_W-1:0]   in_wcode,
   output logic                out_valid,
   input  logic                out_ready,
   output logic                out_is_param,
   output logic                out_last,
   output logic [PAR_W-1:0]    out_param,
   output logic [SAMPLE_W-1:0] out_mi,
   output logic [SAMPLE_W-1:0] out_mq,
   input  logic                dx_valid,
   input  logic [CODE_W-1:0]   dx_wcode,
   input  logic [EXP_W-1:0]    dx_exp,
   input  logic [SAMPLE_W-1:0] dx_mi,
   input  logic [SAMPLE_W-1:0] dx_mq,
   output logic                dx_out_valid,
   output logic [SAMPLE_W-1:0] dx_out_i,
   output logic [SAMPLE_W-1:0] dx_out_q
);
   localparam int MAG_W = SAMPLE_W - 1;
   localparam int WID_W = $clog2(SAMPLE_W + 1);
   localparam int CNT_W = $clog2(GROUP_N + 1);
   localparam int LIM_W = SAMPLE_W + 1;

   // ---------------- elaboration checks ----------------
   if (SAMPLE_W != (1 << CODE_W)) begin : g_chk_code
      $error("bfp_prb_codec: code 0 must stand for SAMPLE_W");
   end
   if (GROUP_N < 1) begin : g_chk_group
      $error("bfp_prb_codec: GROUP_N must be at least 1");
   end
   if (((1 << EXP_W) - 1) < MAG_W || EXP_W > PAR_W) begin : g_chk_exp
      $error("bfp_prb_codec: EXP_W cannot cover every shift");
   end

   // ---------------- compressor state ----------------
   bfp_phase_t          phase;
   logic [CNT_W-1:0]    cnt, idx, sel;
   logic [MAG_W-1:0]    acc, acc_next;
   logic [WID_W-1:0]    wid_r, wid_in, wid_next;
   logic [EXP_W-1:0]    exp_r, exp_next;
   logic [SAMPLE_W-1:0] smp_i [GROUP_N];
   logic [SAMPLE_W-1:0] smp_q [GROUP_N];
   logic                in_fire, out_fire, last_fill;

   logic [SAMPLE_W-1:0] in_lane   [N_LANES];
   logic [MAG_W-1:0]    fold_lane [N_LANES];
   logic [SAMPLE_W-1:0] pick_lane [N_LANES];
   logic [SAMPLE_W-1:0] q_lane    [N_LANES];

   assign in_lane[LANE_I] = in_i;
   assign in_lane[LANE_Q] = in_q;

   for (genvar l = 0; l < N_LANES; l++) begin : g_fold
      bfp_fold_mag #(.SAMPLE_W(SAMPLE_W)) u_fold (
         .v (in_lane[l]),
         .m (fold_lane[l])
      );
   end

   assign in_ready  = (phase == PH_FILL);
   assign in_fire   = in_valid && in_ready;
   assign out_valid = (phase == PH_EMIT);
   assign out_fire  = out_valid && out_ready;
   assign last_fill = (cnt == CNT_W'(GROUP_N - 1));

   always_comb begin
      wid_in   = (in_wcode == '0) ? WID_W'(SAMPLE_W) : WID_W'(in_wcode);
      wid_next = (cnt == '0) ? wid_in : wid_r;
      acc_next = ((cnt == '0) ? '0 : acc) | fold_lane[LANE_I] | fold_lane[LANE_Q];
   end

   bfp_exp_calc #(
      .MAG_W (MAG_W),
      .WID_W (WID_W),
      .EXP_W (EXP_W),
      .ARCH  (EXP_ARCH)
   ) u_exp (
      .mag   (acc_next),
      .width (wid_next),
      .exp_o (exp_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_FILL;
         cnt   <= '0;
         idx   <= '0;
         acc   <= '0;
         wid_r <= WID_W'(SAMPLE_W);
         exp_r <= '0;
      end else begin
         case (phase)
            PH_FILL: begin
               if (in_fire) begin
                  acc   <= acc_next;
                  wid_r <= wid_next;
                  if (last_fill) begin
                     phase <= PH_EMIT;
                     idx   <= '0;
                     cnt   <= '0;
                     exp_r <= exp_next;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
            end
            default: begin
               if (out_fire) begin
                  if (idx == CNT_W'(GROUP_N)) begin
                     phase <= PH_FILL;
                     idx   <= '0;
                  end else begin
                     idx <= idx + CNT_W'(1);
                  end
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (in_fire) begin
         smp_i[cnt] <= in_i;
         smp_q[cnt] <= in_q;
      end
   end

   // ---------------- emission ----------------
   assign sel = (idx == '0) ? '0 : (idx - CNT_W'(1));
   assign pick_lane[LANE_I] = smp_i[sel];
   assign pick_lane[LANE_Q] = smp_q[sel];

   for (genvar l = 0; l < N_LANES; l++) begin : g_quant
      bfp_quant #(
         .SAMPLE_W (SAMPLE_W),
         .WID_W    (WID_W),
         .EXP_W    (EXP_W)
      ) u_quant (
         .v     (pick_lane[l]),
         .sh    (exp_r),
         .width (wid_r),
         .q     (q_lane[l])
      );
   end

   assign out_is_param = (idx == '0);
   assign out_last     = (idx == CNT_W'(GROUP_N));
   assign out_param    = PAR_W'(exp_r);
   assign out_mi       = out_is_param ? '0 : q_lane[LANE_I];
   assign out_mq       = out_is_param ? '0 : q_lane[LANE_Q];

   // ---------------- expansion path ----------------
   logic [WID_W-1:0]    dx_wid;
   logic [SAMPLE_W-1:0] dx_lane_in  [N_LANES];
   logic [SAMPLE_W-1:0] dx_lane_out [N_LANES];

   assign dx_wid = (dx_wcode == '0) ? WID_W'(SAMPLE_W) : WID_W'(dx_wcode);
   assign dx_lane_in[LANE_I] = dx_mi;
   assign dx_lane_in[LANE_Q] = dx_mq;

   for (genvar l = 0; l < N_LANES; l++) begin : g_expand
      bfp_expand #(
         .SAMPLE_W (SAMPLE_W),
         .WID_W    (WID_W),
         .EXP_W    (EXP_W)
      ) u_expand (
         .m     (dx_lane_in[l]),
         .sh    (dx_exp),
         .width (dx_wid),
         .y     (dx_lane_out[l])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dx_out_valid <= 1'b0;
         dx_out_i     <= '0;
         dx_out_q     <= '0;
      end else begin
         dx_out_valid <= dx_valid;
         if (dx_valid) begin
            dx_out_i <= dx_lane_out[LANE_I];
            dx_out_q <= dx_lane_out[LANE_Q];
         end
      end
   end

   // ---------------- assertions ----------------
   logic signed [LIM_W-1:0] mi_top, mq_top;
   logic [LIM_W-1:0]        lim_chk, acc_w;
   always_comb begin
      mi_top  = $signed({out_mi[SAMPLE_W-1], out_mi}) >>> (wid_r - WID_W'(1));
      mq_top  = $signed({out_mq[SAMPLE_W-1], out_mq}) >>> (wid_r - WID_W'(1));
      lim_chk = LIM_W'(1) << (wid_r - WID_W'(1));
      acc_w   = LIM_W'(acc);
   end

   AST_NO_INPUT_WHILE_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready); // R2
   AST_PARAM_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> out_is_param); // R3
   AST_EXP_MINIMAL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_is_param) |-> (((acc_w >> exp_r) < lim_chk) &&
                                       ((exp_r == '0) || ((acc_w >> (exp_r - EXP_W'(1))) >= lim_chk)))); // R5
   AST_MANT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_is_param) |-> (((mi_top == '0) || (mi_top == '1)) &&
                                        ((mq_top == '0) || (mq_top == '1)))); // R6
   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_mi) && $stable(out_mq) &&
                                     $stable(out_is_param) && $stable(out_param))); // R7
   AST_EXPAND_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      dx_valid |=> dx_out_valid); // R8
   AST_EXPAND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !dx_valid |=> !dx_out_valid); // R8
endmodule

// File: tb/bfp_prb_codec_tb.sv
module bfp_prb_codec_tb;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int SW = 16;
   localparam int GN = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [SW-1:0] in_i = '0, in_q = '0;
   logic [3:0]    in_wcode = '0;
   logic          out_valid, out_ready = 1'b0, out_is_param, out_last;
   logic [7:0]    out_param;
   logic [SW-1:0] out_mi, out_mq;
   logic          dx_valid = 1'b0;
   logic [3:0]    dx_wcode = '0, dx_exp = '0;
   logic [SW-1:0] dx_mi = '0, dx_mq = '0;
   logic          dx_out_valid;
   logic [SW-1:0] dx_out_i, dx_out_q;

   always #4 clk = ~clk; // 125 MHz

   bfp_prb_codec u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q), .in_wcode(in_wcode),
      .out_valid(out_valid), .out_ready(out_ready), .out_is_param(out_is_param), .out_last(out_last),
      .out_param(out_param), .out_mi(out_mi), .out_mq(out_mq),
      .dx_valid(dx_valid), .dx_wcode(dx_wcode), .dx_exp(dx_exp), .dx_mi(dx_mi), .dx_mq(dx_mq),
      .dx_out_valid(dx_out_valid), .dx_out_i(dx_out_i), .dx_out_q(dx_out_q)
   );

   int          n_chk = 0;
   int          n_fail = 0;
   logic [31:0] rng = 32'h1234_5678;
   int          gi [GN];
   int          gq [GN];
   int          mi_exp [GN];
   int          mq_exp [GN];
   int          codes [11] = '{0, 8, 9, 10, 11, 12, 13, 14, 15, 1, 4};

   task automatic step_rng();
      rng ^= rng << 13;
      rng ^= rng >> 17;
      rng ^= rng << 5;
   endtask

   task automatic check(input string req, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   function automatic int s16(input int x);
      logic [15:0] t;
      t = 16'(x);
      return int'($signed(t));
   endfunction

   function automatic int wid_of(input int code);
      return (code == 0) ? 16 : code;
   endfunction

   function automatic bit fits(input int x, input int w);
      return (x >= -(1 << (w - 1))) && (x <= (1 << (w - 1)) - 1);
   endfunction

   function automatic int exp_ref(input int w);
      for (int e = 0; e < 15; e++) begin
         bit ok;
         ok = 1'b1;
         for (int k = 0; k < GN; k++) begin
            if (!fits(gi[k] >>> e, w) || !fits(gq[k] >>> e, w)) ok = 1'b0;
         end
         if (ok) return e;
      end
      return 15;
   endfunction

   function automatic int mant_ref(input int v, input int e, input int w);
      int r;
      r = (e == 0) ? v : ((v + (1 << (e - 1))) >>> e);
      if (r > (1 << (w - 1)) - 1) r = (1 << (w - 1)) - 1;
      if (r < -(1 << (w - 1)))    r = -(1 << (w - 1));
      return r;
   endfunction

   task automatic fill_group(input int pat);
      for (int k = 0; k < GN; k++) begin
         step_rng();
         case (pat)
            0: begin gi[k] = k * 100;            gq[k] = -k * 37; end
            1: begin gi[k] = 0;                  gq[k] = 0; end
            2: begin gi[k] = (k == 3) ? -32768 : k; gq[k] = (k == 7) ? 32767 : -k; end
            3: begin gi[k] = s16(int'(rng[15:0])); gq[k] = s16(int'(rng[31:16])); end
            4: begin gi[k] = s16(int'(rng[15:0])) >>> 6; gq[k] = s16(int'(rng[31:16])) >>> 9; end
            5: begin gi[k] = (k == 0) ? 32767 : -1; gq[k] = -1; end
            6: begin gi[k] = -32768;             gq[k] = -32768; end
            default: begin gi[k] = 120 + 2 * k;  gq[k] = -(250 + 3 * k); end
         endcase
      end
   endtask

   // starts and ends on a falling edge
   task automatic push_group(input int code);
      for (int k = 0; k < GN; k++) begin
         step_rng();
         if (rng[1:0] == 2'b00) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_i = SW'(gi[k]);
         in_q = SW'(gq[k]);
         // R4: only the first pair's code counts
         in_wcode = (k == 0) ? 4'(code) : rng[7:4];
         while (!in_ready) @(negedge clk);
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   task automatic recv_group(input int code);
      int w, e;
      bit stall_pend;
      int s_mi, s_mq, s_par;
      w = wid_of(code);
      e = exp_ref(w);
      stall_pend = 1'b0;
      s_mi = 0; s_mq = 0; s_par = 0;
      for (int b = 0; b <= GN; b++) begin
         bit got;
         got = 1'b0;
         while (!got) begin
            step_rng();
            out_ready = rng[2] | rng[3];
            if (stall_pend) begin
               check("R7 stall hold valid", int'(out_valid), 1);
               check("R7 stall hold I", int'(out_mi), s_mi);
               check("R7 stall hold Q", int'(out_mq), s_mq);
               check("R7 stall hold kind", int'(out_is_param), s_par);
               stall_pend = 1'b0;
            end
            if (b == 0) check("R2 input blocked during emission", int'(in_ready), 0);
            if (out_valid && out_ready) begin
               got = 1'b1;
               if (b == 0) begin
                  check("R3 parameter beat first", int'(out_is_param), 1);
                  check("R5 exponent byte", int'(out_param), e);
                  check("R6 parameter beat lanes zero", int'(out_mi) | int'(out_mq), 0);
               end else begin
                  mi_exp[b-1] = mant_ref(gi[b-1], e, w);
                  mq_exp[b-1] = mant_ref(gq[b-1], e, w);
                  check("R3 mantissa beat kind", int'(out_is_param), 0);
                  check("R3 last flag", int'(out_last), (b == GN) ? 1 : 0);
                  check("R6 I mantissa", s16(int'(out_mi)), mi_exp[b-1]);
                  check("R6 Q mantissa", s16(int'(out_mq)), mq_exp[b-1]);
                  if (code == 0) begin
                     check("R9 exact I at width 16", s16(int'(out_mi)), gi[b-1]);
                     check("R9 exact Q at width 16", s16(int'(out_mq)), gq[b-1]);
                  end
               end
            end else if (out_valid) begin
               stall_pend = 1'b1;
               s_mi = int'(out_mi);
               s_mq = int'(out_mq);
               s_par = int'(out_is_param);
            end
            @(negedge clk);
         end
      end
      out_ready = 1'b0;
      check("R2 output idle after group", int'(out_valid), 0);
      check("R2 input reopened after group", int'(in_ready), 1);
   endtask

   task automatic expand_group(input int code);
      int w, e, mask;
      w = wid_of(code);
      e = exp_ref(w);
      mask = (1 << w) - 1;
      for (int k = 0; k < GN; k++) begin
         step_rng();
         dx_valid = 1'b1;
         dx_wcode = 4'(code);
         dx_exp   = 4'(e);
         // R8: bits at and above the width carry noise that must be ignored
         dx_mi = SW'((mi_exp[k] & mask) | (int'(rng[15:0]) & ~mask));
         dx_mq = SW'((mq_exp[k] & mask) | (int'(rng[31:16]) & ~mask));
         @(negedge clk);
         check("R8 expand valid", int'(dx_out_valid), 1);
         check("R8 expand I", s16(int'(dx_out_i)), s16(mi_exp[k] << e));
         check("R8 expand Q", s16(int'(dx_out_q)), s16(mq_exp[k] << e));
      end
      dx_valid = 1'b0;
      @(negedge clk);
      check("R8 expand idle", int'(dx_out_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset out_valid", int'(out_valid), 0);
      check("R1 reset in_ready", int'(in_ready), 1);
      check("R1 reset dx_out_valid", int'(dx_out_valid), 0);
      for (int p = 0; p < 8; p++) begin
         for (int c = 0; c < 11; c++) begin
            fill_group(p);
            push_group(codes[c]);
            recv_group(codes[c]);
            expand_group(codes[c]);
         end
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule